// File: doc/BRIEF.md
# Memory-Mapped NVM Programming Controller

This block connects a byte-wide data-space bus to a paged, word-organised non-volatile array. Software or an external programmer first loads a command code into a command register. It then writes data to a location that maps onto the memory, and that write starts the operation. A countdown timer models how long the operation takes. While it runs, a busy flag is set, the command register refuses new values, and every access to the memory regions is refused. A refused read returns 0xFF and pulses an access-blocked output.

Each bus access is tagged with its source. Only accesses from the external programming port may change the memory. Write attempts that come from the internal CPU side are dropped without any effect. The byte address is split into four parts: a region selector, a page index, a word-in-page index and a high/low byte select.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the busy flag is 0, the command register holds 0x00, and every flash byte and the lock byte read 0xFF.
- R2: Address decode on 8 bits:
    - Bit 7 = 1 selects flash. Within flash, bit 0 selects the high byte (1) or low byte (0), bits [2:1] are the word index and bits [6:3] are the page index.
    - Bits [7:6] = 01 selects the lock byte.
    - Bits [7:6] = 00 selects the registers. Bit 0 = 0 is the status register, whose bit 7 is busy and whose other bits read 0. Bit 0 = 1 is the command register, which reads back its last accepted value.
- R3: Word write uses command 0x1D. An external write to an even flash address stores the low byte in a buffer. An external write to an odd flash address programs that word as {written byte, buffered byte} and starts busy.
- R4: Page erase uses command 0x14. An external write to any flash address sets all four words of that page to 0xFFFF. Other pages are not changed.
- R5: Lock write uses command 0x1A. An external write to the lock region stores the written byte as the lock byte.
- R6: Busy timing. After the triggering write, busy reads 1 for exactly 8 cycles following a word write or lock write, and for exactly 16 cycles following a page erase.
- R7: A write to the command register while busy is ignored.
- R8: While busy:
    - A flash or lock read returns 0xFF instead of the stored data.
    - A flash or lock write changes nothing.
    - Each such access raises acc_blocked for one cycle.
- R9: A flash or lock write with bus_ext = 0 never changes memory and never sets busy.
- R10: With command 0x00 or any unrecognised code, a write to flash or lock is ignored and does not set busy.
- R11: Every read request produces bus_rvalid, with bus_rdata valid, in the cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, sampled at each rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ext | input | 1 | 1 = access comes from the external programming port, 0 = from the CPU |
| bus_addr | input | 8 | Data-space byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read response strobe |
| acc_blocked | output | 1 | One-cycle pulse for each memory access refused because the block is busy |

## Verification
The two functions that collide are the busy countdown expiring and a new memory access arriving. The bench places reads back to back around the trigger. A flash read sampled in the last busy cycle must come back as 0xFF with acc_blocked set. The same read one cycle later must return the stored byte with no block.

The bench also places command-register writes and external flash writes inside the busy window. It then reads back the command register and the target word after the window closes, to show that neither write took effect.

// File: rtl/nvm_pkg.sv
// Shared definitions for the NVM programming controller: command codes,
// access regions and the array operation selector.
package nvm_pkg;

    localparam logic [7:0] CMD_NOP     = 8'h00;
    localparam logic [7:0] CMD_WORD_WR = 8'h1D;
    localparam logic [7:0] CMD_PAGE_ER = 8'h14;
    localparam logic [7:0] CMD_LOCK_WR = 8'h1A;

    typedef enum logic [1:0] {
        RGN_CSR   = 2'd0,
        RGN_CMD   = 2'd1,
        RGN_LOCK  = 2'd2,
        RGN_FLASH = 2'd3
    } nvm_region_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WORD = 2'd1,
        OP_PAGE = 2'd2,
        OP_LOCK = 2'd3
    } nvm_op_e;

endpackage

// File: rtl/nvm_addr_split.sv
// Splits a data-space byte address into region, page, word and byte select.
// Assumes ADDR_W = PAGE_BITS + WORD_BITS + 2. The top bit selects flash. The
// next bit selects the lock byte. Otherwise bit 0 picks status or command.
module nvm_addr_split
    import nvm_pkg::*;
#(
    parameter int WORD_BITS = 2,
    parameter int PAGE_BITS = 4,
    localparam int ADDR_W   = PAGE_BITS + WORD_BITS + 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output nvm_region_e          region,
    output logic [PAGE_BITS-1:0] page,
    output logic [WORD_BITS-1:0] word,
    output logic                 hi_byte
);

    // Field extraction: fixed bit positions inside the flash window.
    assign hi_byte = addr[0];
    assign word    = addr[WORD_BITS:1];
    assign page    = addr[PAGE_BITS+WORD_BITS:WORD_BITS+1];

    // Region decode from the most significant address bits.
    always_comb begin
        if (addr[ADDR_W-1])
            region = RGN_FLASH;
        else if (addr[ADDR_W-2])
            region = RGN_LOCK;
        else if (addr[0])
            region = RGN_CMD;
        else
            region = RGN_CSR;
    end

endmodule

// File: rtl/nvm_busy_timer.sv
// Countdown that models the duration of an NVM operation.
// busy is high for exactly load_len cycles after the edge on which load is seen.
// Assumes load is only raised while busy is low.
module nvm_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             busy
);

    logic [CNT_W-1:0] cnt;

    // Load the duration on a trigger, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_len;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/nvm_array.sv
// Behavioural storage for the paged flash words and the lock byte.
// Every cell resets to the erased value (all ones). A word op replaces one
// word, a page op erases every word of one page, a lock op replaces the lock byte.
// The read port is combinational on page, word and byte select.
module nvm_array
    import nvm_pkg::*;
#(
    parameter int WORD_BITS = 2,
    parameter int PAGE_BITS = 4,
    localparam int IDX_W    = PAGE_BITS + WORD_BITS,
    localparam int N_WORDS  = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  nvm_op_e              op,
    input  logic [PAGE_BITS-1:0] op_page,
    input  logic [WORD_BITS-1:0] op_word,
    input  logic [15:0]          op_wdata,
    input  logic [7:0]           op_lock,
    input  logic [PAGE_BITS-1:0] rd_page,
    input  logic [WORD_BITS-1:0] rd_word,
    input  logic                 rd_hi,
    output logic [7:0]           rd_byte,
    output logic [7:0]           lock_q
);

    logic [15:0] cells [N_WORDS];

    // One storage word per address, each with its own match logic.
    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = gi[IDX_W-1:0];
        logic page_hit;
        logic word_hit;
        assign page_hit = (op_page == MY_IDX[IDX_W-1:WORD_BITS]);
        assign word_hit = page_hit && (op_word == MY_IDX[WORD_BITS-1:0]);

        // Update this word on a matching word write or page erase.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[gi] <= 16'hFFFF;
            else if (op == OP_WORD && word_hit)
                cells[gi] <= op_wdata;
            else if (op == OP_PAGE && page_hit)
                cells[gi] <= 16'hFFFF;
        end
    end

    // Lock byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 8'hFF;
        else if (op == OP_LOCK)
            lock_q <= op_lock;
    end

    // Byte select on the addressed word.
    logic [15:0] rd_word_q;
    assign rd_word_q = cells[{rd_page, rd_word}];
    assign rd_byte   = rd_hi ? rd_word_q[15:8] : rd_word_q[7:0];

endmodule

// File: rtl/nvm_prog_ctrl.sv
// NVM programming controller top.
// Decodes bus accesses to the status register, command register, lock byte
// and flash. A loaded command starts an operation when the external port
// writes to a matching memory region. While the countdown runs, command
// writes are dropped and memory accesses are refused (reads give 0xFF).
// Reads respond one cycle after the request. Assumes single-cycle requests.
module nvm_prog_ctrl
    import nvm_pkg::*;
#(
    parameter int WORD_BITS = 2,
    parameter int PAGE_BITS = 4,
    parameter int WR_CYCLES = 8,
    parameter int ER_CYCLES = 16,
    localparam int ADDR_W   = PAGE_BITS + WORD_BITS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_ext,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    output logic              acc_blocked
);

    localparam int MAX_CYC = (WR_CYCLES > ER_CYCLES) ? WR_CYCLES : ER_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WR_LEN = CNT_W'(WR_CYCLES);
    localparam logic [CNT_W-1:0] ER_LEN = CNT_W'(ER_CYCLES);

    nvm_region_e          region;
    logic [PAGE_BITS-1:0] a_page;
    logic [WORD_BITS-1:0] a_word;
    logic                 a_hi;
    logic                 busy;
    logic [7:0]           cmd_q;
    logic [7:0]           lo_buf;
    logic                 tgt_nvm;
    logic                 tgt_cmd;
    logic                 trig;
    logic                 lo_cap;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_len;
    nvm_op_e              op_sel;
    logic [7:0]           arr_byte;
    logic [7:0]           arr_lock;

    nvm_addr_split #(
        .WORD_BITS (WORD_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_split (
        .addr    (bus_addr),
        .region  (region),
        .page    (a_page),
        .word    (a_word),
        .hi_byte (a_hi)
    );

    nvm_busy_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_len (tmr_len),
        .busy     (busy)
    );

    nvm_array #(
        .WORD_BITS (WORD_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_sel),
        .op_page  (a_page),
        .op_word  (a_word),
        .op_wdata ({bus_wdata, lo_buf}),
        .op_lock  (bus_wdata),
        .rd_page  (a_page),
        .rd_word  (a_word),
        .rd_hi    (a_hi),
        .rd_byte  (arr_byte),
        .lock_q   (arr_lock)
    );

    // Target classification for blocking and command-lock decisions.
    assign tgt_nvm = (region == RGN_FLASH) || (region == RGN_LOCK);
    assign tgt_cmd = (region == RGN_CMD);

    // A memory write that is allowed to act: external source, idle controller.
    assign trig = bus_req && bus_we && bus_ext && tgt_nvm && !busy;

    // Command decode: choose the array operation, low-byte capture and duration.
    always_comb begin
        op_sel   = OP_NONE;
        lo_cap   = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = WR_LEN;
        if (trig) begin
            case (cmd_q)
                CMD_WORD_WR: begin
                    if (region == RGN_FLASH) begin
                        if (a_hi) begin
                            op_sel   = OP_WORD;
                            tmr_load = 1'b1;
                        end else begin
                            lo_cap = 1'b1;
                        end
                    end
                end
                CMD_PAGE_ER: begin
                    if (region == RGN_FLASH) begin
                        op_sel   = OP_PAGE;
                        tmr_load = 1'b1;
                        tmr_len  = ER_LEN;
                    end
                end
                CMD_LOCK_WR: begin
                    if (region == RGN_LOCK) begin
                        op_sel   = OP_LOCK;
                        tmr_load = 1'b1;
                    end
                end
                default: op_sel = OP_NONE;
            endcase
        end
    end

    // Command register: accepts writes only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= CMD_NOP;
        else if (bus_req && bus_we && tgt_cmd && !busy)
            cmd_q <= bus_wdata;
    end

    // Low-byte buffer for the two-step word write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_buf <= 8'hFF;
        else if (lo_cap)
            lo_buf <= bus_wdata;
    end

    // Read response: registered data selected by region, blocked reads give 0xFF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= 8'h00;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            if (bus_req && !bus_we) begin
                case (region)
                    RGN_CSR:   bus_rdata <= {busy, 7'b0};
                    RGN_CMD:   bus_rdata <= cmd_q;
                    RGN_LOCK:  bus_rdata <= busy ? 8'hFF : arr_lock;
                    RGN_FLASH: bus_rdata <= busy ? 8'hFF : arr_byte;
                    default:   bus_rdata <= 8'h00;
                endcase
            end
        end
    end

    // Blocked-access pulse for any memory access refused while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_blocked <= 1'b0;
        else
            acc_blocked <= bus_req && tgt_nvm && busy;
    end

endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
// Property checker for nvm_prog_ctrl, attached by bind. Observes bus ports
// and the busy flag, command register and target decode of the top.
module nvm_prog_ctrl_chk #(
    parameter int ER_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_we,
    input logic       bus_ext,
    input logic [7:0] bus_rdata,
    input logic       bus_rvalid,
    input logic       acc_blocked,
    input logic       busy,
    input logic [7:0] cmd_q,
    input logic       tgt_nvm,
    input logic       tgt_cmd
);

    logic [15:0] run_len;

    // Length of the current busy stretch so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else
            run_len <= busy ? run_len + 1'b1 : '0;
    end

    // R7
    cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_req && bus_we && tgt_cmd) |=> $stable(cmd_q));

    // R8
    read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_req && !bus_we && tgt_nvm) |=> (bus_rvalid && acc_blocked && bus_rdata == 8'hFF));

    // R8
    block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_blocked |-> $past(busy));

    // R9
    cpu_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_req && bus_we && !bus_ext) |=> !busy);

    // R6
    busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_req && bus_we && bus_ext && tgt_nvm));

    // R6
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < 16'(ER_CYCLES)));

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk #(.ER_CYCLES(ER_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_ext     (bus_ext),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .acc_blocked (acc_blocked),
    .busy        (busy),
    .cmd_q       (cmd_q),
    .tgt_nvm     (tgt_nvm),
    .tgt_cmd     (tgt_cmd)
);

// File: tb/tb_nvm_prog_ctrl.sv
// Scoreboard bench: driver tasks queue the expected responses and a monitor
// compares them against what the controller produces.
module tb_nvm_prog_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_ext = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic       acc_blocked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic       q_rd [$];
    logic       q_blk [$];
    logic [7:0] q_dat [$];
    string      q_tag [$];

    localparam logic [7:0] A_CSR  = 8'h00;
    localparam logic [7:0] A_CMD  = 8'h01;
    localparam logic [7:0] A_LOCK = 8'h40;

    nvm_prog_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_ext     (bus_ext),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid),
        .acc_blocked (acc_blocked)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] fa(input int pg, input int wd, input int hi);
        return 8'h80 | 8'(pg << 3) | 8'(wd << 1) | 8'(hi);
    endfunction

    // One bus cycle, starting and ending at a falling edge.
    task automatic bus_op(input logic we, input logic ext, input logic [7:0] a, input logic [7:0] d);
        bus_req = 1'b1; bus_we = we; bus_ext = ext; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic expect_item(input logic rd, input logic blk, input logic [7:0] d, input string tag);
        q_rd.push_back(rd); q_blk.push_back(blk); q_dat.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input logic blk, input string tag);
        expect_item(1'b1, blk, exp, tag);
        bus_op(1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic wr(input logic ext, input logic [7:0] a, input logic [7:0] d);
        bus_op(1'b1, ext, a, d);
    endtask

    task automatic wr_blk(input logic [7:0] a, input logic [7:0] d, input string tag);
        expect_item(1'b0, 1'b1, 8'h00, tag);
        bus_op(1'b1, 1'b1, a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every response or block pulse must match the next queued item.
    always @(negedge clk) begin
        if (rst_n && (bus_rvalid || acc_blocked)) begin
            n_tests++;
            if (q_rd.size() == 0) begin
                n_fail++;
                $display("FAIL R11/R8 unexpected response: rvalid=%0b blocked=%0b expected none",
                         bus_rvalid, acc_blocked);
            end else begin
                logic       e_rd;
                logic       e_blk;
                logic [7:0] e_dat;
                string      e_tag;
                e_rd = q_rd.pop_front(); e_blk = q_blk.pop_front();
                e_dat = q_dat.pop_front(); e_tag = q_tag.pop_front();
                if (bus_rvalid !== e_rd || acc_blocked !== e_blk ||
                    (e_rd && bus_rdata !== e_dat)) begin
                    n_fail++;
                    $display("FAIL %s: rvalid=%0b blocked=%0b data=%02h expected rvalid=%0b blocked=%0b data=%02h",
                             e_tag, bus_rvalid, acc_blocked, bus_rdata, e_rd, e_blk, e_dat);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(A_CSR, 8'h00, 1'b0, "R1 status after reset");
        rd(A_CMD, 8'h00, 1'b0, "R1 command after reset");
        rd(fa(5, 1, 1), 8'hFF, 1'b0, "R1 flash erased after reset");
        rd(A_LOCK, 8'hFF, 1'b0, "R1 lock after reset");

        // R3, R6: word write p3 w2 = 0x1234, busy for 8 cycles
        wr(1'b1, A_CMD, 8'h1D);
        wr(1'b1, fa(3, 2, 0), 8'h34);
        rd(A_CSR, 8'h00, 1'b0, "R3 low byte write does not start busy");
        wr(1'b1, fa(3, 2, 1), 8'h12);
        for (int i = 0; i < 8; i++) rd(A_CSR, 8'h80, 1'b0, "R6 busy during word write");
        rd(A_CSR, 8'h00, 1'b0, "R6 busy clear after 8 cycles");
        rd(fa(3, 2, 0), 8'h34, 1'b0, "R2 R3 low byte of programmed word");
        rd(fa(3, 2, 1), 8'h12, 1'b0, "R2 R3 high byte of programmed word");
        wr(1'b1, fa(2, 3, 0), 8'h66);
        wr(1'b1, fa(2, 3, 1), 8'h5A);
        idle(9);

        // R7, R8: accesses inside the busy window and at its edge
        wr(1'b1, fa(3, 1, 0), 8'hCD);
        wr(1'b1, fa(3, 1, 1), 8'hAB);
        rd(fa(3, 2, 0), 8'hFF, 1'b1, "R8 read blocked while busy");
        wr_blk(fa(0, 0, 1), 8'h00, "R8 write blocked while busy");
        wr(1'b1, A_CMD, 8'h14);
        for (int i = 0; i < 4; i++) rd(A_CSR, 8'h80, 1'b0, "R6 busy mid window");
        rd(fa(3, 2, 0), 8'hFF, 1'b1, "R8 read in last busy cycle blocked");
        rd(fa(3, 2, 0), 8'h34, 1'b0, "R8 read right after expiry returns data");
        rd(A_CMD, 8'h1D, 1'b0, "R7 command write while busy ignored");
        rd(fa(3, 1, 1), 8'hAB, 1'b0, "R3 second word high");
        rd(fa(3, 1, 0), 8'hCD, 1'b0, "R3 second word low");
        rd(fa(0, 0, 1), 8'hFF, 1'b0, "R8 blocked write left memory unchanged");

        // R4, R6: page erase of page 3, 16 busy cycles
        wr(1'b1, A_CMD, 8'h14);
        wr(1'b1, fa(3, 0, 1), 8'h00);
        for (int i = 0; i < 16; i++) rd(A_CSR, 8'h80, 1'b0, "R6 busy during page erase");
        rd(A_CSR, 8'h00, 1'b0, "R6 busy clear after 16 cycles");
        rd(fa(3, 2, 0), 8'hFF, 1'b0, "R4 erased word 2 low");
        rd(fa(3, 1, 1), 8'hFF, 1'b0, "R4 erased word 1 high");
        rd(fa(2, 3, 1), 8'h5A, 1'b0, "R4 other page kept high");
        rd(fa(2, 3, 0), 8'h66, 1'b0, "R4 other page kept low");

        // R5: lock write
        wr(1'b1, A_CMD, 8'h1A);
        wr(1'b1, A_LOCK, 8'h3C);
        for (int i = 0; i < 8; i++) rd(A_CSR, 8'h80, 1'b0, "R6 busy during lock write");
        rd(A_CSR, 8'h00, 1'b0, "R6 busy clear after lock write");
        rd(A_LOCK, 8'h3C, 1'b0, "R5 lock byte written");

        // R9: CPU-side writes have no effect
        wr(1'b0, A_CMD, 8'h1D);
        wr(1'b0, fa(1, 0, 0), 8'h11);
        wr(1'b0, fa(1, 0, 1), 8'h22);
        rd(A_CSR, 8'h00, 1'b0, "R9 CPU word write starts no busy");
        rd(fa(1, 0, 1), 8'hFF, 1'b0, "R9 CPU word write left flash");
        wr(1'b0, A_CMD, 8'h1A);
        wr(1'b0, A_LOCK, 8'h00);
        rd(A_CSR, 8'h00, 1'b0, "R9 CPU lock write starts no busy");
        rd(A_LOCK, 8'h3C, 1'b0, "R9 CPU lock write left lock");

        // R10: unknown and no-op commands
        wr(1'b1, A_CMD, 8'h55);
        rd(A_CMD, 8'h55, 1'b0, "R2 command readback");
        wr(1'b1, fa(1, 0, 0), 8'h00);
        wr(1'b1, fa(1, 0, 1), 8'h00);
        rd(A_CSR, 8'h00, 1'b0, "R10 unknown command starts no busy");
        rd(fa(1, 0, 1), 8'hFF, 1'b0, "R10 unknown command left flash");
        wr(1'b1, A_CMD, 8'h00);
        wr(1'b1, A_LOCK, 8'h00);
        rd(A_CSR, 8'h00, 1'b0, "R10 no-op starts no busy");
        rd(A_LOCK, 8'h3C, 1'b0, "R10 no-op left lock");

        idle(3);
        n_tests++;
        if (q_rd.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing responses: %0d outstanding expected 0", q_rd.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule